// File: doc/BRIEF.md
# CAN Sleep and Wake-Up Mode Controller

This block governs how a CAN protocol engine enters and leaves its low-power sleep state. Software requests sleep by writing a two-bit power-save field. The request waits until the bus is idle before it takes effect. Initialization-mode requests take priority over a waiting sleep request. While asleep, the block gates the engine clock and blocks register writes, except writes to the power-save field.

The block wakes in one of two ways: software writes the field back to zero, or the synchronized receive line falls from recessive to dominant. On wake, the block reports the operating mode that was active when sleep was requested, so the engine can resume it. A wake caused by the bus raises a sticky interrupt flag. The engine then rejoins the bus only after eleven consecutive recessive bit samples. The block itself runs on a free-running clock, so it can still see the receive line while the engine clock is gated.

Top module: `can_sleep_ctrl`

## Requirements
- R1: A sleep request (write of 01 to the power-save field while running) sets the pending indication. The block enters sleep only on the cycle after `bus_idle_i` is sampled high.
- R2: An initialization request made while a sleep request is waiting leads to initialization mode instead of sleep. The pending indication stays set until the field is written to 00.
- R3: A sleep request written while an initialization request is waiting for the bus is recorded in the field and in the pending indication, but the block never enters sleep from it.
- R4: In sleep, `clk_en_o` and `reg_wr_en_o` are low. The power-save field still accepts a write of 01.
- R5: An initialization request made during sleep is ignored: the block stays asleep and `init_mode_o` stays low.
- R6: Writing 00 to the field during sleep wakes the block on the next clock edge.
- R7: A falling receive line wakes the block on the third clock edge after the pin changes, because of the two-stage synchronizer and the edge detector. A wake from the bus sets `wake_irq_o`.
- R8: On every wake, `resume_vld_o` pulses for one cycle. `resume_mode_o` carries the operating mode captured with the sleep request, and the field reads 00.
- R9: A 00 write and a bus wake edge in the same cycle count as a software wake, and `wake_irq_o` stays low.
- R10: `bus_en_o` rises only after 11 consecutive bit-tick samples of recessive (1) receive level. A dominant sample restarts the count. Sleep clears it.
- R11: Field writes of 10 or 11 have no effect, in any state.
- R12: `wake_irq_o` stays set until `wake_irq_clr_i` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_wr_i | input | 1 | Write strobe for the power-save field |
| mode_wdata_i | input | 2 | Value written: 00 awake, 01 sleep, others ignored |
| init_req_i | input | 1 | Initialization-mode request (level) |
| op_mode_i | input | OPW | Current operating mode of the engine |
| bus_idle_i | input | 1 | Bus has no frame in progress |
| rx_i | input | 1 | Receive pin, 1 recessive, 0 dominant |
| bit_tick_i | input | 1 | One pulse per nominal bit time |
| wake_irq_clr_i | input | 1 | Clears the wake-up interrupt flag |
| mode_field_o | output | 2 | Current power-save field value |
| sleep_pend_o | output | 1 | Sleep request recorded but not in sleep |
| in_sleep_o | output | 1 | Block is asleep |
| init_mode_o | output | 1 | Initialization mode granted |
| clk_en_o | output | 1 | Engine clock-gate enable |
| reg_wr_en_o | output | 1 | General register and buffer access permitted |
| wake_irq_o | output | 1 | Bus wake-up interrupt status |
| resume_vld_o | output | 1 | One-cycle pulse on wake |
| resume_mode_o | output | OPW | Operating mode to restore |
| bus_en_o | output | 1 | Engine may participate on the bus |

## Verification
On every cycle, the assertions check several rules:
- sleep is entered only after an idle bus;
- an initialization request never disturbs sleep;
- a waiting initialization request never turns into sleep;
- the interrupt rises only on a bus wake that software did not also trigger;
- each resume pulse follows sleep with a cleared field;
- the rejoin enable rises only on a recessive tick.

The bench scenarios show what properties cannot:
- the exact three-edge wake latency;
- that the restored mode equals the one captured at request time, for every mode value and every wake kind;
- the exact count of eleven recessive ticks, swept from zero to thirteen;
- that the pending indication is retained across the initialization arbitration.

// File: rtl/can_slp_pkg.sv
package can_slp_pkg;

  typedef enum logic [2:0] {
    ST_RUN       = 3'd0,
    ST_SLP_WAIT  = 3'd1,
    ST_INIT_WAIT = 3'd2,
    ST_INIT      = 3'd3,
    ST_SLEEP     = 3'd4
  } slp_state_e;

  localparam logic [1:0] PSM_AWAKE = 2'b00;
  localparam logic [1:0] PSM_SLEEP = 2'b01;

endpackage

// File: rtl/can_rx_edge.sv
module can_rx_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic rx_s_o,
  output logic fall_o
);

  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q, sync_d;
  logic         last_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb sync_d = rx_i;
    end else begin : g_chain
      always_comb sync_d = {sync_q[MSB-1:0], rx_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[MSB];
    end
  end

  assign rx_s_o = sync_q[MSB];
  assign fall_o = last_q & ~sync_q[MSB];

endmodule

// File: rtl/can_rejoin_cnt.sv
module can_rejoin_cnt #(
  parameter int RUN_LEN = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  input  logic rx_i,
  output logic rejoin_o
);

  localparam int              CW      = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0]   RUN_MAX = CW'(RUN_LEN);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (!rx_i)                cnt_d = '0;
      else if (cnt_q < RUN_MAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign rejoin_o = (cnt_q == RUN_MAX);

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= RUN_MAX); // R10
  AST_REJOIN_ON_RECESSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rejoin_o) |-> $past(tick_i && rx_i && !clr_i)); // R10
  AST_DOMINANT_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !rx_i) |=> !rejoin_o); // R10

endmodule

// File: rtl/can_slp_fsm.sv
module can_slp_fsm
  import can_slp_pkg::*;
#(
  parameter int OPW = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           mode_wr_i,
  input  logic [1:0]     mode_wdata_i,
  input  logic           init_req_i,
  input  logic [OPW-1:0] op_mode_i,
  input  logic           bus_idle_i,
  input  logic           rx_fall_i,
  input  logic           irq_clr_i,
  output slp_state_e     state_o,
  output logic [1:0]     field_o,
  output logic           irq_o,
  output logic           resume_vld_o,
  output logic [OPW-1:0] resume_mode_o
);

  slp_state_e     state_q, state_d;
  logic [1:0]     field_q, field_d;
  logic           irq_q, irq_d;
  logic [OPW-1:0] save_q, save_d;
  logic           resume_q, resume_d;
  logic           wr_sleep, wr_wake;

  assign wr_sleep = mode_wr_i && (mode_wdata_i == PSM_SLEEP);
  assign wr_wake  = mode_wr_i && (mode_wdata_i == PSM_AWAKE);

  always_comb begin
    state_d  = state_q;
    field_d  = field_q;
    irq_d    = irq_q;
    save_d   = save_q;
    resume_d = 1'b0;
    if (wr_sleep || wr_wake) field_d = mode_wdata_i;
    if (irq_clr_i)           irq_d   = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (init_req_i) begin
          state_d = ST_INIT_WAIT;
        end else if (wr_sleep) begin
          state_d = ST_SLP_WAIT;
          save_d  = op_mode_i;
        end
      end
      ST_SLP_WAIT: begin
        if (init_req_i)      state_d = ST_INIT_WAIT;
        else if (wr_wake)    state_d = ST_RUN;
        else if (bus_idle_i) state_d = ST_SLEEP;
      end
      ST_INIT_WAIT: begin
        if (!init_req_i)     state_d = ST_RUN;
        else if (bus_idle_i) state_d = ST_INIT;
      end
      ST_INIT: begin
        if (!init_req_i) state_d = ST_RUN;
      end
      ST_SLEEP: begin
        if (wr_wake) begin
          state_d  = ST_RUN;
          resume_d = 1'b1;
        end else if (rx_fall_i) begin
          state_d  = ST_RUN;
          resume_d = 1'b1;
          field_d  = PSM_AWAKE;
          irq_d    = 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_RUN;
      field_q  <= PSM_AWAKE;
      irq_q    <= 1'b0;
      save_q   <= '0;
      resume_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      field_q  <= field_d;
      irq_q    <= irq_d;
      save_q   <= save_d;
      resume_q <= resume_d;
    end
  end

  assign state_o       = state_q;
  assign field_o       = field_q;
  assign irq_o         = irq_q;
  assign resume_vld_o  = resume_q;
  assign resume_mode_o = save_q;

  AST_SLEEP_AFTER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_SLEEP) |-> $past(bus_idle_i)); // R1
  AST_INIT_IGNORED_ASLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP && init_req_i && !wr_wake && !rx_fall_i) |=> (state_q == ST_SLEEP)); // R5
  AST_INIT_WAIT_NO_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_INIT_WAIT && init_req_i) |=> (state_q == ST_INIT_WAIT || state_q == ST_INIT)); // R3
  AST_IRQ_FROM_BUS_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(state_q == ST_SLEEP && rx_fall_i && !wr_wake)); // R7 R9
  AST_RESUME_AFTER_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_q |-> ($past(state_q) == ST_SLEEP && state_q == ST_RUN && field_q == PSM_AWAKE)); // R8

endmodule

// File: rtl/can_sleep_ctrl.sv
module can_sleep_ctrl
  import can_slp_pkg::*;
#(
  parameter int OPW         = 2,
  parameter int REJOIN_BITS = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           mode_wr_i,
  input  logic [1:0]     mode_wdata_i,
  input  logic           init_req_i,
  input  logic [OPW-1:0] op_mode_i,
  input  logic           bus_idle_i,
  input  logic           rx_i,
  input  logic           bit_tick_i,
  input  logic           wake_irq_clr_i,
  output logic [1:0]     mode_field_o,
  output logic           sleep_pend_o,
  output logic           in_sleep_o,
  output logic           init_mode_o,
  output logic           clk_en_o,
  output logic           reg_wr_en_o,
  output logic           wake_irq_o,
  output logic           resume_vld_o,
  output logic [OPW-1:0] resume_mode_o,
  output logic           bus_en_o
);

  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic       rx_s, rx_fall, rejoin;
  slp_state_e state;
  logic [1:0] field;

  can_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .rx_i   (rx_i),
    .rx_s_o (rx_s),
    .fall_o (rx_fall)
  );

  can_slp_fsm #(.OPW(OPW)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .mode_wr_i     (mode_wr_i),
    .mode_wdata_i  (mode_wdata_i),
    .init_req_i    (init_req_i),
    .op_mode_i     (op_mode_i),
    .bus_idle_i    (bus_idle_i),
    .rx_fall_i     (rx_fall),
    .irq_clr_i     (wake_irq_clr_i),
    .state_o       (state),
    .field_o       (field),
    .irq_o         (wake_irq_o),
    .resume_vld_o  (resume_vld_o),
    .resume_mode_o (resume_mode_o)
  );

  can_rejoin_cnt #(.RUN_LEN(REJOIN_BITS)) u_rejoin (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .clr_i    (in_sleep_o),
    .tick_i   (bit_tick_i),
    .rx_i     (rx_s),
    .rejoin_o (rejoin)
  );

  assign in_sleep_o   = (state == ST_SLEEP);
  assign init_mode_o  = (state == ST_INIT);
  assign clk_en_o     = ~in_sleep_o;
  assign reg_wr_en_o  = ~in_sleep_o;
  assign mode_field_o = field;
  assign sleep_pend_o = (field == PSM_SLEEP) && !in_sleep_o;
  assign bus_en_o     = rejoin && !in_sleep_o;

  AST_ASLEEP_NO_BUS: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(in_sleep_o) |=> !bus_en_o); // R10

endmodule

// File: tb/can_sleep_ctrl_test.sv
module can_sleep_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int OPW        = 2;
  localparam int RUN_LEN    = 11;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           mode_wr;
  logic [1:0]     mode_wdata;
  logic           init_req;
  logic [OPW-1:0] op_mode;
  logic           bus_idle;
  logic           rx;
  logic           tick;
  logic           irq_clr;
  logic [1:0]     field;
  logic           sleep_pend, in_sleep, init_mode, clk_en, reg_wr_en;
  logic           wake_irq, resume_vld, bus_en;
  logic [OPW-1:0] resume_mode;

  int vec_cnt = 0;
  int err_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_sleep_ctrl #(.OPW(OPW), .REJOIN_BITS(RUN_LEN), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_wr_i(mode_wr), .mode_wdata_i(mode_wdata),
    .init_req_i(init_req), .op_mode_i(op_mode), .bus_idle_i(bus_idle), .rx_i(rx),
    .bit_tick_i(tick), .wake_irq_clr_i(irq_clr), .mode_field_o(field),
    .sleep_pend_o(sleep_pend), .in_sleep_o(in_sleep), .init_mode_o(init_mode),
    .clk_en_o(clk_en), .reg_wr_en_o(reg_wr_en), .wake_irq_o(wake_irq),
    .resume_vld_o(resume_vld), .resume_mode_o(resume_mode), .bus_en_o(bus_en)
  );

  task automatic step(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [1:0] v);
    mode_wr = 1'b1;
    mode_wdata = v;
    step();
    mode_wr = 1'b0;
  endtask

  task automatic go_sleep(input logic [OPW-1:0] m);
    op_mode  = m;
    bus_idle = 1'b0;
    wr_mode(2'b01);
    bus_idle = 1'b1;
    step();
    op_mode  = ~m;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    err_cnt++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_wr = 1'b0; mode_wdata = 2'b00; init_req = 1'b0;
    op_mode = '0; bus_idle = 1'b0; rx = 1'b1; tick = 1'b0; irq_clr = 1'b0;
    step(2);
    // reset state
    chk("reset in_sleep", in_sleep, 0);
    chk("reset clk_en", clk_en, 1);
    chk("reset reg_wr_en", reg_wr_en, 1);
    chk("reset field", field, 0);
    chk("reset irq", wake_irq, 0);
    chk("reset bus_en", bus_en, 0);
    chk("reset init_mode", init_mode, 0);
    chk("reset sleep_pend", sleep_pend, 0);
    rst_n = 1'b1;
    step(3);

    // R10 sweep: k recessive ticks after a dominant tick
    for (int k = 0; k <= 13; k++) begin
      rx = 1'b0; step(2);
      tick = 1'b1; step(); tick = 1'b0;
      chk("R10 dominant restart", bus_en, 0);
      rx = 1'b1; step(2);
      tick = 1'b1; step(k); tick = 1'b0;
      chk("R10 recessive count", bus_en, (k >= RUN_LEN) ? 1 : 0);
    end

    // R11: reserved codes ignored while running
    bus_idle = 1'b1;
    wr_mode(2'b10); step(3);
    chk("R11 field after 10", field, 0);
    chk("R11 no sleep after 10", in_sleep, 0);
    wr_mode(2'b11); step(3);
    chk("R11 field after 11", field, 0);
    chk("R11 no sleep after 11", in_sleep, 0);

    // R1: sleep waits for idle bus
    op_mode = 2'd2; bus_idle = 1'b0;
    wr_mode(2'b01);
    chk("R1 pending", sleep_pend, 1);
    chk("R1 not asleep yet", in_sleep, 0);
    step(3);
    chk("R1 still waiting", in_sleep, 0);
    bus_idle = 1'b1; op_mode = 2'd1; step();
    chk("R1 asleep after idle", in_sleep, 1);
    chk("R4 clk gated", clk_en, 0);
    chk("R4 writes blocked", reg_wr_en, 0);
    chk("R10 bus_en cleared in sleep", bus_en, 0);

    // R4 / R11 in sleep
    wr_mode(2'b01);
    chk("R4 field writable", field, 1);
    chk("R4 still asleep", in_sleep, 1);
    wr_mode(2'b10);
    chk("R11 field in sleep", field, 1);
    // R5
    init_req = 1'b1; step(3);
    chk("R5 asleep", in_sleep, 1);
    chk("R5 no init", init_mode, 0);
    init_req = 1'b0;
    // R6 software wake
    wr_mode(2'b00);
    chk("R6 awake", in_sleep, 0);
    chk("R8 resume pulse", resume_vld, 1);
    chk("R8 resume mode", resume_mode, 2);
    chk("R6 no irq", wake_irq, 0);
    chk("R10 bus_en after wake", bus_en, 0);
    step();
    chk("R8 pulse one cycle", resume_vld, 0);
    tick = 1'b1; step(RUN_LEN - 1); tick = 1'b0;
    chk("R10 one short", bus_en, 0);
    tick = 1'b1; step(); tick = 1'b0;
    chk("R10 rejoined", bus_en, 1);

    // mode x wake-kind sweep: R6 R7 R8 R9
    for (int m = 0; m < 4; m++) begin
      for (int kind = 0; kind < 3; kind++) begin
        irq_clr = 1'b1; step(); irq_clr = 1'b0;
        go_sleep(m[OPW-1:0]);
        chk("R1 sweep asleep", in_sleep, 1);
        if (kind == 0) begin
          wr_mode(2'b00);
        end else if (kind == 1) begin
          rx = 1'b0; step(2);
          chk("R7 latency not yet", in_sleep, 1);
          step();
        end else begin
          rx = 1'b0; step(2);
          chk("R9 still asleep", in_sleep, 1);
          mode_wr = 1'b1; mode_wdata = 2'b00; step(); mode_wr = 1'b0;
        end
        chk("R7 awake", in_sleep, 0);
        chk("R8 resume pulse", resume_vld, 1);
        chk("R8 resume mode", resume_mode, m);
        chk("R8 field zero", field, 0);
        chk((kind == 2) ? "R9 irq" : "R7 irq", wake_irq, (kind == 1) ? 1 : 0);
        rx = 1'b1; step(3);
      end
    end

    // R12 sticky irq
    irq_clr = 1'b1; step(); irq_clr = 1'b0;
    go_sleep(2'd3);
    rx = 1'b0; step(3); rx = 1'b1; step(6);
    chk("R12 irq held", wake_irq, 1);
    go_sleep(2'd0); wr_mode(2'b00);
    chk("R12 irq held over cpu wake", wake_irq, 1);
    irq_clr = 1'b1; step(); irq_clr = 1'b0;
    chk("R12 irq cleared", wake_irq, 0);

    // R2: init overrides waiting sleep
    bus_idle = 1'b0;
    wr_mode(2'b01);
    init_req = 1'b1; step();
    chk("R2 pending kept", sleep_pend, 1);
    chk("R2 init not yet", init_mode, 0);
    bus_idle = 1'b1; step();
    chk("R2 init granted", init_mode, 1);
    chk("R2 not asleep", in_sleep, 0);
    chk("R2 pending during init", sleep_pend, 1);
    init_req = 1'b0; step(3);
    chk("R2 never slept", in_sleep, 0);
    chk("R2 init left", init_mode, 0);
    wr_mode(2'b00);
    chk("R2 pending cleared", sleep_pend, 0);

    // R3: sleep write while init waits
    bus_idle = 1'b0; init_req = 1'b1; step();
    wr_mode(2'b01);
    chk("R3 field recorded", field, 1);
    chk("R3 pending shown", sleep_pend, 1);
    bus_idle = 1'b1; step();
    chk("R3 init granted", init_mode, 1);
    chk("R3 not asleep", in_sleep, 0);
    init_req = 1'b0; step(4);
    chk("R3 sleep ignored", in_sleep, 0);
    wr_mode(2'b00);

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule